// File: doc/BRIEF.md
# Glitch-Free Multi-Domain Clock Stop Controller

This block sits between the clock synthesizer and the clock output pins of a system clock generator. It receives three free-running source clocks (a processor clock, a peripheral-bus clock and a memory clock). From each source it drives a group of gated copies. The peripheral-bus group has one extra output that ignores its group's stop request. Every group has its own active-low stop request, and one shared active-low power-down request covers all groups. Each request may change at any time. Each output also has a static enable bit from a configuration register, where 1 lets the output run and 0 holds it low.

Each request is synchronized into the domain of the clock it gates. The gate that decides whether an output may pulse is updated only on the falling edge of its source clock. A stopped output therefore sits low, and a restarted output always begins with a high phase of full width. After a group restarts, it keeps running for a minimum number of source cycles before a new stop request is obeyed. Power-down cuts across that minimum.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every output is held low. After reset each group opens only once its synchronized requests allow it.
- R2: The processor stop request passes two source-clock flops. When `cpu_stop_n` changes just after a rising `cpu_clk` edge, a stop lets the outputs pulse on the 1st and 2nd following rising edges and suppresses the 3rd and all later ones. A restart gives the first pulse on the 3rd following rising edge. Both latencies are under 4 cycles.
- R3: After the processor group restarts it produces at least `CPU_MIN_ON` (default 100) pulses before a stop is obeyed. When stop is reasserted right after the first restart pulse, exactly 100 pulses appear.
- R4: The peripheral-bus stop request passes one `pci_clk` flop. A stop leaves exactly one more pulse, and a restart pulses on the 2nd following rising edge. Once restarted, the group gives at least `PCI_MIN_ON` (default 10) pulses, and exactly 10 when stop is reasserted right after the first pulse.
- R5: `pci_free_out` keeps pulsing on every `pci_clk` rising edge whatever `pci_stop_n` does. Only its enable bit and power-down stop it.
- R6: The memory stop request passes two `sdr_clk` flops. It has the same latencies as R2, with a minimum run of `SDR_MIN_ON` (default 4) pulses after a restart.
- R7: A stop request on one group leaves every other group pulsing on each rising edge of its own source.
- R8: An enable bit at 0 holds that single output low from the 3rd source rising edge on. The other outputs of the group keep running. Bit i of `cpu_en`, `pci_en` and `sdr_en` controls output bit i.
- R9: With `pwr_dn_n` low, every output, the free-running one included, is low from the 3rd rising edge of its source on. Power-down overrides the minimum run: asserted right after a processor restart pulse, it lets exactly 3 processor pulses out.
- R10: Every high phase of every output lasts a full half period of its source clock. Gate enables change only while the source clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | Processor source clock |
| pci_clk | input | 1 | Peripheral-bus source clock |
| sdr_clk | input | 1 | Memory source clock |
| cpu_stop_n | input | 1 | Asynchronous processor group stop request, active low |
| pci_stop_n | input | 1 | Peripheral-bus group stop request, active low |
| sdr_stop_n | input | 1 | Asynchronous memory group stop request, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_en | input | N_CPU | Per-output enable bits of the processor group |
| pci_en | input | N_PCI | Per-output enable bits of the stoppable peripheral-bus outputs |
| pci_free_en | input | 1 | Enable bit of the free-running peripheral-bus output |
| sdr_en | input | N_SDR | Per-output enable bits of the memory group |
| cpu_out | output | N_CPU | Gated processor clocks |
| pci_out | output | N_PCI | Gated peripheral-bus clocks |
| pci_free_out | output | 1 | Peripheral-bus clock exempt from the group stop |
| sdr_out | output | N_SDR | Gated memory clocks |

## Verification
A synchronizer that is a flop too long or too short moves the first missing or first restored pulse by one source edge, so the latency probes detect it on the first stop or restart of that group. A minimum-run counter that is miscounted or not honored changes the pulse count of a short restart burst from its exact expected value within about a hundred cycles. A gate updated on the wrong clock edge shows up as a high phase shorter than half a period at the very next transition. A wrong group or bit mapping shows at once as pulses missing or surplus in a counting window.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_CPU      = 3,
  parameter int N_PCI      = 5,
  parameter int N_SDR      = 13,
  parameter int CPU_MIN_ON = 100,
  parameter int PCI_MIN_ON = 10,
  parameter int SDR_MIN_ON = 4
) (
  input  logic             rst_n,
  input  logic             cpu_clk,
  input  logic             pci_clk,
  input  logic             sdr_clk,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             sdr_stop_n,
  input  logic             pwr_dn_n,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_PCI-1:0] pci_en,
  input  logic             pci_free_en,
  input  logic [N_SDR-1:0] sdr_en,
  output logic [N_CPU-1:0] cpu_out,
  output logic [N_PCI-1:0] pci_out,
  output logic             pci_free_out,
  output logic [N_SDR-1:0] sdr_out
);

  localparam int CPU_CW = $clog2(CPU_MIN_ON + 1);
  localparam int PCI_CW = $clog2(PCI_MIN_ON + 1);
  localparam int SDR_CW = $clog2(SDR_MIN_ON + 1);
  localparam logic [CPU_CW-1:0] CPU_TOP = CPU_CW'(CPU_MIN_ON);
  localparam logic [PCI_CW-1:0] PCI_TOP = PCI_CW'(PCI_MIN_ON);
  localparam logic [SDR_CW-1:0] SDR_TOP = SDR_CW'(SDR_MIN_ON);

  // processor group
  logic [1:0]        cpu_req_s, cpu_pd_s;
  logic [N_CPU-1:0]  cpu_cfg_a, cpu_cfg_b, cpu_oe;
  logic [CPU_CW-1:0] cpu_run;
  logic              cpu_gate;
  logic              cpu_next;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_req_s <= '0;
      cpu_pd_s  <= '0;
      cpu_cfg_a <= '0;
      cpu_cfg_b <= '0;
      cpu_run   <= '0;
    end else begin
      cpu_req_s <= {cpu_req_s[0], cpu_stop_n};
      cpu_pd_s  <= {cpu_pd_s[0], pwr_dn_n};
      cpu_cfg_a <= cpu_en;
      cpu_cfg_b <= cpu_cfg_a;
      if (!cpu_gate)            cpu_run <= '0;
      else if (cpu_run != CPU_TOP) cpu_run <= cpu_run + 1'b1;
    end
  end

  assign cpu_next = cpu_pd_s[1] && (cpu_req_s[1] || (cpu_gate && cpu_run != CPU_TOP));

  always_ff @(negedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_gate <= 1'b0;
      cpu_oe   <= '0;
    end else begin
      cpu_gate <= cpu_next;
      cpu_oe   <= {N_CPU{cpu_next}} & cpu_cfg_b;
    end
  end

  assign cpu_out = {N_CPU{cpu_clk}} & cpu_oe;

  // peripheral-bus group
  logic              pci_req_s;
  logic [1:0]        pci_pd_s;
  logic [N_PCI-1:0]  pci_cfg_a, pci_cfg_b, pci_oe;
  logic              pci_free_a, pci_free_b, pci_free_oe;
  logic [PCI_CW-1:0] pci_run;
  logic              pci_gate;
  logic              pci_next;

  always_ff @(posedge pci_clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_req_s  <= 1'b0;
      pci_pd_s   <= '0;
      pci_cfg_a  <= '0;
      pci_cfg_b  <= '0;
      pci_free_a <= 1'b0;
      pci_free_b <= 1'b0;
      pci_run    <= '0;
    end else begin
      pci_req_s  <= pci_stop_n;
      pci_pd_s   <= {pci_pd_s[0], pwr_dn_n};
      pci_cfg_a  <= pci_en;
      pci_cfg_b  <= pci_cfg_a;
      pci_free_a <= pci_free_en;
      pci_free_b <= pci_free_a;
      if (!pci_gate)            pci_run <= '0;
      else if (pci_run != PCI_TOP) pci_run <= pci_run + 1'b1;
    end
  end

  assign pci_next = pci_pd_s[1] && (pci_req_s || (pci_gate && pci_run != PCI_TOP));

  always_ff @(negedge pci_clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_gate    <= 1'b0;
      pci_oe      <= '0;
      pci_free_oe <= 1'b0;
    end else begin
      pci_gate    <= pci_next;
      pci_oe      <= {N_PCI{pci_next}} & pci_cfg_b;
      pci_free_oe <= pci_pd_s[1] && pci_free_b;
    end
  end

  assign pci_out      = {N_PCI{pci_clk}} & pci_oe;
  assign pci_free_out = pci_clk & pci_free_oe;

  // memory group
  logic [1:0]        sdr_req_s, sdr_pd_s;
  logic [N_SDR-1:0]  sdr_cfg_a, sdr_cfg_b, sdr_oe;
  logic [SDR_CW-1:0] sdr_run;
  logic              sdr_gate;
  logic              sdr_next;

  always_ff @(posedge sdr_clk or negedge rst_n) begin
    if (!rst_n) begin
      sdr_req_s <= '0;
      sdr_pd_s  <= '0;
      sdr_cfg_a <= '0;
      sdr_cfg_b <= '0;
      sdr_run   <= '0;
    end else begin
      sdr_req_s <= {sdr_req_s[0], sdr_stop_n};
      sdr_pd_s  <= {sdr_pd_s[0], pwr_dn_n};
      sdr_cfg_a <= sdr_en;
      sdr_cfg_b <= sdr_cfg_a;
      if (!sdr_gate)            sdr_run <= '0;
      else if (sdr_run != SDR_TOP) sdr_run <= sdr_run + 1'b1;
    end
  end

  assign sdr_next = sdr_pd_s[1] && (sdr_req_s[1] || (sdr_gate && sdr_run != SDR_TOP));

  always_ff @(negedge sdr_clk or negedge rst_n) begin
    if (!rst_n) begin
      sdr_gate <= 1'b0;
      sdr_oe   <= '0;
    end else begin
      sdr_gate <= sdr_next;
      sdr_oe   <= {N_SDR{sdr_next}} & sdr_cfg_b;
    end
  end

  assign sdr_out = {N_SDR{sdr_clk}} & sdr_oe;

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N_CPU      = 3,
  parameter int N_PCI      = 5,
  parameter int N_SDR      = 13,
  parameter int CPU_MIN_ON = 100
) (
  input logic             rst_n,
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             pwr_dn_n,
  input logic [N_CPU-1:0] cpu_en,
  input logic             pci_free_en,
  input logic [N_CPU-1:0] cpu_out,
  input logic [N_PCI-1:0] pci_out,
  input logic             pci_free_out,
  input logic [N_SDR-1:0] sdr_out,
  input logic             cpu_gate,
  input logic [N_CPU-1:0] cpu_oe
);

  localparam int RW = $clog2(CPU_MIN_ON + 2);

  logic [2:0]    age_cp, age_cn, age_pn;
  logic [RW-1:0] on_len;

  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n) begin
      age_cp <= '0;
      on_len <= '0;
    end else begin
      if (age_cp != 3'd7) age_cp <= age_cp + 3'd1;
      if (!cpu_gate) on_len <= '0;
      else if (on_len != RW'(CPU_MIN_ON + 1)) on_len <= on_len + 1'b1;
    end

  always_ff @(negedge cpu_clk or negedge rst_n)
    if (!rst_n) age_cn <= '0;
    else if (age_cn != 3'd7) age_cn <= age_cn + 3'd1;

  always_ff @(negedge pci_clk or negedge rst_n)
    if (!rst_n) age_pn <= '0;
    else if (age_pn != 3'd7) age_pn <= age_pn + 3'd1;

  // R1
  a_r1_reset_low: assert property (@(negedge cpu_clk)
    !rst_n |-> (cpu_out == '0 && pci_out == '0 && sdr_out == '0 && !pci_free_out));

  // R3
  a_r3_min_on: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (age_cp >= 3'd4 && $fell(cpu_gate) && pwr_dn_n && $past(pwr_dn_n) &&
     $past(pwr_dn_n, 2) && $past(pwr_dn_n, 3)) |-> (on_len >= RW'(CPU_MIN_ON)));

  // R5
  a_r5_free_runs: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (age_pn >= 3'd4 && pwr_dn_n && $past(pwr_dn_n) && $past(pwr_dn_n, 2) && $past(pwr_dn_n, 3) &&
     pci_free_en && $past(pci_free_en) && $past(pci_free_en, 2) && $past(pci_free_en, 3))
    |-> pci_free_out);

  // R8
  for (genvar i = 0; i < N_CPU; i++) begin : g_bit
    a_r8_bit_low: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      (age_cn >= 3'd4 && !cpu_en[i] && !$past(cpu_en[i]) && !$past(cpu_en[i], 2) &&
       !$past(cpu_en[i], 3)) |-> !cpu_out[i]);
  end

  // R9
  a_r9_pd_cpu: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (age_cn >= 3'd4 && !pwr_dn_n && !$past(pwr_dn_n) && !$past(pwr_dn_n, 2) &&
     !$past(pwr_dn_n, 3)) |-> (cpu_out == '0));

  a_r9_pd_free: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (age_pn >= 3'd4 && !pwr_dn_n && !$past(pwr_dn_n) && !$past(pwr_dn_n, 2) &&
     !$past(pwr_dn_n, 3)) |-> !pci_free_out);

  // R10
  always @(cpu_oe)
    if (rst_n) a_r10_gate_moves_low: assert (!cpu_clk);

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_SDR(N_SDR), .CPU_MIN_ON(CPU_MIN_ON)
) u_chk (
  .rst_n(rst_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pwr_dn_n(pwr_dn_n),
  .cpu_en(cpu_en), .pci_free_en(pci_free_en), .cpu_out(cpu_out), .pci_out(pci_out),
  .pci_free_out(pci_free_out), .sdr_out(sdr_out), .cpu_gate(cpu_gate), .cpu_oe(cpu_oe)
);

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/1ps
module tb_clk_stop_gate;
  localparam int CLK_PERIOD = 10;
  localparam int PCI_PERIOD = 30;
  localparam int SDR_PERIOD = 14;
  localparam int N_CPU = 3, N_PCI = 5, N_SDR = 13;

  logic cpu_clk = 0, pci_clk = 0, sdr_clk = 0;
  logic rst_n;
  logic cpu_stop_n, pci_stop_n, sdr_stop_n, pwr_dn_n, pci_free_en;
  logic [N_CPU-1:0] cpu_en;
  logic [N_PCI-1:0] pci_en;
  logic [N_SDR-1:0] sdr_en;
  logic [N_CPU-1:0] cpu_out;
  logic [N_PCI-1:0] pci_out;
  logic [N_SDR-1:0] sdr_out;
  logic pci_free_out;

  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
  always #(PCI_PERIOD/2) pci_clk = ~pci_clk;
  always #(SDR_PERIOD/2) sdr_clk = ~sdr_clk;

  clk_stop_gate dut (
    .rst_n(rst_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdr_clk(sdr_clk),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .sdr_stop_n(sdr_stop_n),
    .pwr_dn_n(pwr_dn_n), .cpu_en(cpu_en), .pci_en(pci_en), .pci_free_en(pci_free_en),
    .sdr_en(sdr_en), .cpu_out(cpu_out), .pci_out(pci_out), .pci_free_out(pci_free_out),
    .sdr_out(sdr_out)
  );

  int n_chk = 0, n_fail = 0, runts = 0;
  int src_cpu = 0, src_pci = 0, src_sdr = 0, n_free = 0;
  int n_cpu[N_CPU], n_pci[N_PCI], n_sdr[N_SDR];
  bit e_cpu[N_CPU], e_pci[N_PCI], e_sdr[N_SDR], e_free;
  real t_free;

  always @(posedge cpu_clk) src_cpu++;
  always @(posedge pci_clk) src_pci++;
  always @(posedge sdr_clk) src_sdr++;
  always @(posedge pci_free_out) begin n_free++; t_free = $realtime; end
  always @(negedge pci_free_out)
    if (rst_n && $realtime - t_free < PCI_PERIOD/2.0 - 0.01) runts++;

  for (genvar g = 0; g < N_CPU; g++) begin : g_c
    real t;
    initial n_cpu[g] = 0;
    always @(posedge cpu_out[g]) begin n_cpu[g]++; t = $realtime; end
    always @(negedge cpu_out[g]) if (rst_n && $realtime - t < CLK_PERIOD/2.0 - 0.01) runts++;
  end
  for (genvar g = 0; g < N_PCI; g++) begin : g_p
    real t;
    initial n_pci[g] = 0;
    always @(posedge pci_out[g]) begin n_pci[g]++; t = $realtime; end
    always @(negedge pci_out[g]) if (rst_n && $realtime - t < PCI_PERIOD/2.0 - 0.01) runts++;
  end
  for (genvar g = 0; g < N_SDR; g++) begin : g_s
    real t;
    initial n_sdr[g] = 0;
    always @(posedge sdr_out[g]) begin n_sdr[g]++; t = $realtime; end
    always @(negedge sdr_out[g]) if (rst_n && $realtime - t < SDR_PERIOD/2.0 - 0.01) runts++;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_exp(bit c, bit p, bit f, bit s);
    for (int i = 0; i < N_CPU; i++) e_cpu[i] = c;
    for (int i = 0; i < N_PCI; i++) e_pci[i] = p;
    for (int i = 0; i < N_SDR; i++) e_sdr[i] = s;
    e_free = f;
  endtask

  task automatic window(string tag);
    int bc[N_CPU]; int bp[N_PCI]; int bs[N_SDR];
    int sc, sp, ss, bf;
    @(posedge cpu_clk); #1;
    bc = n_cpu; bp = n_pci; bs = n_sdr; bf = n_free;
    sc = src_cpu; sp = src_pci; ss = src_sdr;
    #600;
    for (int i = 0; i < N_CPU; i++)
      check($sformatf("%s cpu_out[%0d]", tag, i), n_cpu[i] - bc[i], e_cpu[i] ? src_cpu - sc : 0);
    for (int i = 0; i < N_PCI; i++)
      check($sformatf("%s pci_out[%0d]", tag, i), n_pci[i] - bp[i], e_pci[i] ? src_pci - sp : 0);
    for (int i = 0; i < N_SDR; i++)
      check($sformatf("%s sdr_out[%0d]", tag, i), n_sdr[i] - bs[i], e_sdr[i] ? src_sdr - ss : 0);
    check($sformatf("%s pci_free_out", tag), n_free - bf, e_free ? src_pci - sp : 0);
  endtask

  task automatic wait_src(int d);
    case (d)
      0: @(posedge cpu_clk);
      1: @(posedge pci_clk);
      default: @(posedge sdr_clk);
    endcase
    #1;
  endtask

  function automatic logic probe(int d);
    case (d)
      0: return cpu_out[0];
      1: return pci_out[0];
      default: return sdr_out[0];
    endcase
  endfunction

  task automatic drive_stop(int d, logic v);
    case (d)
      0: cpu_stop_n = v;
      1: pci_stop_n = v;
      default: sdr_stop_n = v;
    endcase
  endtask

  task automatic latency(int d, logic v, int exp, string tag);
    int k = 0;
    wait_src(d);
    drive_stop(d, v);
    for (int i = 1; i <= 8; i++) begin
      wait_src(d);
      if (k == 0 && probe(d) == v) k = i;
    end
    check(tag, k, exp);
  endtask

  task automatic burst(int d, bit use_pd, int exp, string tag);
    int cnt = 1;
    drive_stop(d, 0);
    repeat (150) wait_src(d);
    drive_stop(d, 1);
    for (int i = 0; i < 10 && probe(d) == 0; i++) wait_src(d);
    if (use_pd) pwr_dn_n = 0; else drive_stop(d, 0);
    repeat (200) begin wait_src(d); if (probe(d)) cnt++; end
    check(tag, cnt, exp);
    pwr_dn_n = 1;
    drive_stop(d, 1);
    repeat (150) wait_src(d);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired, all requirements actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0;
    cpu_stop_n = 1; pci_stop_n = 1; sdr_stop_n = 1; pwr_dn_n = 1;
    cpu_en = '1; pci_en = '1; sdr_en = '1; pci_free_en = 1;
    for (int t = 0; t < 4; t++) begin
      #23;
      check("R1 reset cpu_out", int'(cpu_out), 0);
      check("R1 reset pci_out", int'(pci_out), 0);
      check("R1 reset sdr_out", int'(sdr_out), 0);
      check("R1 reset pci_free_out", int'(pci_free_out), 0);
    end
    rst_n = 1;
    #2000;

    set_exp(1, 1, 1, 1);
    window("R7 all running");

    latency(0, 0, 3, "R2 cpu stop latency");
    latency(0, 1, 3, "R2 cpu restart latency");
    repeat (150) wait_src(0);
    latency(1, 0, 2, "R4 pci stop latency");
    latency(1, 1, 2, "R4 pci restart latency");
    repeat (150) wait_src(1);
    latency(2, 0, 3, "R6 sdr stop latency");
    latency(2, 1, 3, "R6 sdr restart latency");
    repeat (150) wait_src(2);

    burst(0, 0, 100, "R3 cpu minimum run");
    burst(1, 0, 10, "R4 pci minimum run");
    burst(2, 0, 4, "R6 sdr minimum run");
    burst(0, 1, 3, "R9 power-down overrides cpu minimum");

    cpu_stop_n = 0; #100;
    set_exp(0, 1, 1, 1);
    window("R7 cpu stopped");
    cpu_stop_n = 1; #1500;

    pci_stop_n = 0; #200;
    set_exp(1, 0, 1, 1);
    window("R5 R7 pci stopped");
    pci_stop_n = 1; #600;

    sdr_stop_n = 0; #200;
    set_exp(1, 1, 1, 0);
    window("R7 sdr stopped");
    sdr_stop_n = 1; #600;

    cpu_en[1] = 0; pci_en[4] = 0; sdr_en[12] = 0; pci_free_en = 0;
    #300;
    set_exp(1, 1, 0, 1);
    e_cpu[1] = 0; e_pci[4] = 0; e_sdr[12] = 0;
    window("R8 enable bits cleared");
    cpu_en = '1; pci_en = '1; sdr_en = '1; pci_free_en = 1;
    #300;

    pwr_dn_n = 0; #200;
    set_exp(0, 0, 0, 0);
    window("R9 power-down");
    pwr_dn_n = 1; #600;

    set_exp(1, 1, 1, 1);
    window("R9 after power-down");

    check("R10 runt high phases", runts, 0);
    finish_run();
  end
endmodule